// File: doc/BRIEF.md
# L2 Allocation and Read-Source Selector

This block sits at the front of a shared second-level cache in a multi-core cluster. For each request it decides two things: whether the line is written into the set-associative L2, and, for reads, where the data comes from. The source is the L2 itself, another core's L1 (by snoop), or the external system. The policy is mostly exclusive. Ordinary data enters the L2 only when an L1 evicts it. Instruction fetches are kept on their way in. Loads marked transient or non-temporal go into the L2 but bypass the L1.

The L2 tag lookup and the duplicate-tag lookup for the peer cores arrive together, in the same cycle as the request. The block holds a valid bit for every way of every set and one round-robin victim pointer per set. With these it picks the way to fill: the lowest free way first, and otherwise the way the set's pointer names. All results are registered and appear one clock after the request.

Top module: `l2_alloc_sel`

## Requirements
- R1: A request with `rq_kind` = 2'b10 (L1 eviction) raises `alloc_vld` one cycle later. It never raises `serve_l2`, `snoop_vld`, `ext_fetch` or `fill_l1`.
- R2: A data read (`rq_kind` = 2'b00, `rq_transient` low) that misses both lookups raises `ext_fetch` and `fill_l1` one cycle later, and `alloc_vld` stays low.
- R3: A read that misses both lookups and is either a non-temporal load (`rq_kind` = 2'b11) or carries `rq_transient` raises `ext_fetch` and `alloc_vld` one cycle later, with `fill_l1` low.
- R4: An instruction fetch (`rq_kind` = 2'b01) that misses both lookups raises `ext_fetch`, `alloc_vld` and `fill_l1` one cycle later.
- R5: A read that hits the L2 raises `serve_l2` one cycle later, with `snoop_vld`, `ext_fetch` and `alloc_vld` low, even when a duplicate tag also hits.
- R6: A read that misses the L2 but hits a duplicate tag raises `snoop_vld` one cycle later, with `snoop_core` equal to `dup_core`. `ext_fetch` and `alloc_vld` stay low.
- R7: An allocation into a set that still has an invalid way uses the lowest-numbered invalid way and marks it valid. The set's pointer does not move.
- R8: An allocation into a full set uses the way named by that set's pointer, and the pointer then advances by one, wrapping from the last way to way 0.
- R9: An eviction that hits the L2 allocates to `l2_hit_way` and leaves the set's valid bits and pointer unchanged.
- R10: Sets are independent. An allocation in one set does not change another set's free ways or pointer.
- R11: After reset every output is low, every way is invalid and every pointer is 0. With `rq_valid` low, every strobe is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rq_valid | input | 1 | Request present this cycle |
| rq_kind | input | 2 | 00 data read, 01 instruction fetch, 10 L1 eviction, 11 non-temporal load |
| rq_transient | input | 1 | Transient hint on the request |
| rq_set | input | SET_W | Set index |
| l2_hit | input | 1 | L2 tag hit |
| l2_hit_way | input | WAY_W | Way that hit in L2 |
| dup_hit | input | 1 | A peer core's duplicate tag hit |
| dup_core | input | CORE_W | Index of that peer core |
| alloc_vld | output | 1 | Write the line into L2 |
| alloc_way | output | WAY_W | Way to write |
| serve_l2 | output | 1 | Read served from L2 |
| snoop_vld | output | 1 | Snoop a peer core |
| snoop_core | output | CORE_W | Core to snoop |
| ext_fetch | output | 1 | Fetch from the external system |
| fill_l1 | output | 1 | Requesting L1 keeps the returned line |

## Verification
Every result appears exactly one clock after the request: the decision and the way choice are combinational, and a single output register follows them. The pointer and valid-bit updates land on that same edge, so the next request sees them. The bench drives each request on a falling edge and lowers `rq_valid` on the next falling edge. It checks the outputs at that point, after exactly one rising edge. For multi-request sequences it predicts each way from the history of free ways and pointers in that set.

// File: rtl/l2as_pkg.sv
// Shared request encoding for the L2 allocation selector.
package l2as_pkg;
    typedef enum logic [1:0] {
        RQ_DATA   = 2'b00,
        RQ_INSTR  = 2'b01,
        RQ_EVICT  = 2'b10,
        RQ_NTLOAD = 2'b11
    } rq_kind_t;
endpackage

// File: rtl/l2as_policy.sv
// Combinational policy: maps request kind, hint and lookup hits to
// source choice and allocate intent. Assumes lookups are valid with rq.
module l2as_policy
    import l2as_pkg::*;
(
    input  logic     rq_valid,
    input  rq_kind_t rq_kind,
    input  logic     rq_transient,
    input  logic     l2_hit,
    input  logic     dup_hit,
    output logic     want_serve,
    output logic     want_snoop,
    output logic     want_ext,
    output logic     want_alloc,
    output logic     want_l1,
    output logic     use_hit_way
);
    logic is_read;
    logic l2_only;

    // Classify the request and pick a source and allocation.
    always_comb begin
        is_read     = rq_valid && (rq_kind != RQ_EVICT);
        l2_only     = rq_transient || (rq_kind == RQ_NTLOAD);
        want_serve  = is_read && l2_hit;
        want_snoop  = is_read && !l2_hit && dup_hit;
        want_ext    = is_read && !l2_hit && !dup_hit;
        want_alloc  = (rq_valid && rq_kind == RQ_EVICT) ||
                      (want_ext && (l2_only || rq_kind == RQ_INSTR));
        want_l1     = want_ext && !l2_only;
        use_hit_way = rq_valid && rq_kind == RQ_EVICT && l2_hit;
    end
endmodule

// File: rtl/l2as_victim.sv
// Per-set way chooser: lowest invalid way first, else a round-robin
// pointer per set. Assumes at most one allocation per cycle.
module l2as_victim #(
    parameter int WAYS  = 16,
    parameter int SETS  = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic             use_hit,
    input  logic [WAY_W-1:0] hit_way,
    input  logic [SET_W-1:0] set_idx,
    output logic [WAY_W-1:0] vict_way
);
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAY_W-1:0] ptr_q   [SETS];
    logic             has_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] ptr_next;

    // Find the lowest invalid way of the addressed set.
    always_comb begin
        has_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_q[set_idx][w]) begin
                has_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    // Advance the pointer with wrap at the last way.
    always_comb begin
        if (ptr_q[set_idx] == WAY_W'(WAYS - 1)) ptr_next = '0;
        else                                    ptr_next = ptr_q[set_idx] + 1'b1;
    end

    // Choose the way: hit way, then a free way, then the pointer.
    always_comb begin
        if (use_hit)       vict_way = hit_way;
        else if (has_free) vict_way = free_way;
        else               vict_way = ptr_q[set_idx];
    end

    // Record valid ways and advance pointers on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                ptr_q[s]   <= '0;
            end
        end else if (alloc_en && !use_hit) begin
            if (has_free) valid_q[set_idx][free_way] <= 1'b1;
            else          ptr_q[set_idx]             <= ptr_next;
        end
    end

    AST_FREE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en && !use_hit && has_free |=> valid_q[$past(set_idx)][$past(vict_way)]); // R7
    AST_FREE_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en && !use_hit && has_free |=> ptr_q[$past(set_idx)] == $past(ptr_q[set_idx])); // R7
    AST_FULL_PTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en && !use_hit && !has_free |=> ptr_q[$past(set_idx)] != $past(ptr_q[set_idx])); // R8
    AST_HIT_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en && use_hit |=> ptr_q[$past(set_idx)] == $past(ptr_q[set_idx])); // R9
endmodule

// File: rtl/l2_alloc_sel.sv
// Top: L2 allocation and read-source selector. Registers every result
// one cycle after the request. Assumes tag and duplicate-tag lookups
// arrive in the request cycle.
module l2_alloc_sel
    import l2as_pkg::*;
#(
    parameter int WAYS  = 16,
    parameter int SETS  = 16,
    parameter int CORES = 4,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int SET_W  = $clog2(SETS),
    localparam int CORE_W = (CORES > 1) ? $clog2(CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rq_valid,
    input  logic [1:0]        rq_kind,
    input  logic              rq_transient,
    input  logic [SET_W-1:0]  rq_set,
    input  logic              l2_hit,
    input  logic [WAY_W-1:0]  l2_hit_way,
    input  logic              dup_hit,
    input  logic [CORE_W-1:0] dup_core,
    output logic              alloc_vld,
    output logic [WAY_W-1:0]  alloc_way,
    output logic              serve_l2,
    output logic              snoop_vld,
    output logic [CORE_W-1:0] snoop_core,
    output logic              ext_fetch,
    output logic              fill_l1
);
    logic             want_serve, want_snoop, want_ext, want_alloc, want_l1, use_hit_way;
    logic [WAY_W-1:0] vict_way;

    l2as_policy u_policy (
        .rq_valid     (rq_valid),
        .rq_kind      (rq_kind_t'(rq_kind)),
        .rq_transient (rq_transient),
        .l2_hit       (l2_hit),
        .dup_hit      (dup_hit),
        .want_serve   (want_serve),
        .want_snoop   (want_snoop),
        .want_ext     (want_ext),
        .want_alloc   (want_alloc),
        .want_l1      (want_l1),
        .use_hit_way  (use_hit_way)
    );

    l2as_victim #(.WAYS(WAYS), .SETS(SETS)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_en (want_alloc),
        .use_hit  (use_hit_way),
        .hit_way  (l2_hit_way),
        .set_idx  (rq_set),
        .vict_way (vict_way)
    );

    // Register the decisions so all results land one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_vld  <= 1'b0;
            alloc_way  <= '0;
            serve_l2   <= 1'b0;
            snoop_vld  <= 1'b0;
            snoop_core <= '0;
            ext_fetch  <= 1'b0;
            fill_l1    <= 1'b0;
        end else begin
            alloc_vld  <= want_alloc;
            alloc_way  <= want_alloc ? vict_way : '0;
            serve_l2   <= want_serve;
            snoop_vld  <= want_snoop;
            snoop_core <= want_snoop ? dup_core : '0;
            ext_fetch  <= want_ext;
            fill_l1    <= want_l1;
        end
    end

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({serve_l2, snoop_vld, ext_fetch})); // R5
    AST_EVICT_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid && rq_kind == 2'b10 |=> alloc_vld && !ext_fetch && !fill_l1); // R1
    AST_DATA_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid && rq_kind == 2'b00 && !rq_transient |=> !alloc_vld); // R2
    AST_INSTR_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid && rq_kind == 2'b01 && !l2_hit && !dup_hit |=> alloc_vld && fill_l1); // R4
    AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid && rq_kind != 2'b10 && l2_hit |=> serve_l2 && !snoop_vld && !alloc_vld); // R5
    AST_SNOOP_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid && rq_kind != 2'b10 && !l2_hit && dup_hit |=> snoop_vld && snoop_core == $past(dup_core)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rq_valid |=> !alloc_vld && !serve_l2 && !snoop_vld && !ext_fetch); // R11
endmodule

// File: tb/sim_l2_alloc_sel.sv
module sim_l2_alloc_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rq_valid = 1'b0;
    logic [1:0] rq_kind = 2'b00;
    logic       rq_transient = 1'b0;
    logic [3:0] rq_set = '0;
    logic       l2_hit = 1'b0;
    logic [3:0] l2_hit_way = '0;
    logic       dup_hit = 1'b0;
    logic [1:0] dup_core = '0;
    logic       alloc_vld, serve_l2, snoop_vld, ext_fetch, fill_l1;
    logic [3:0] alloc_way;
    logic [1:0] snoop_core;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    l2_alloc_sel u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one request, wait one rising edge, leave sampling at the falling edge.
    task automatic issue(input logic [1:0] k, input logic tr, input logic [3:0] s,
                         input logic h, input logic [3:0] hw, input logic d, input logic [1:0] c);
        @(negedge clk);
        rq_valid = 1'b1; rq_kind = k; rq_transient = tr; rq_set = s;
        l2_hit = h; l2_hit_way = hw; dup_hit = d; dup_core = c;
        @(negedge clk);
        rq_valid = 1'b0;
    endtask

    // Compare all result strobes in one packed vector {alloc,serve,snoop,ext,fill}.
    task automatic chk_strobes(input string req, input logic [4:0] exp);
        chk(req, {alloc_vld, serve_l2, snoop_vld, ext_fetch, fill_l1}, exp);
    endtask

    task automatic t_reset;
        chk_strobes("R11 reset strobes", 5'b00000);
        chk("R11 reset way", alloc_way, 0);
        @(negedge clk);
        chk_strobes("R11 idle strobes", 5'b00000);
    endtask

    task automatic t_reads;
        issue(2'b00, 0, 4'd1, 0, 0, 0, 0);
        chk_strobes("R2 data miss", 5'b00011);
        issue(2'b00, 1, 4'd1, 0, 0, 0, 0);
        chk_strobes("R3 transient miss", 5'b10010);
        chk("R3 transient way", alloc_way, 0);
        issue(2'b11, 0, 4'd1, 0, 0, 0, 0);
        chk_strobes("R3 ntload miss", 5'b10010);
        chk("R7 second free way", alloc_way, 1);
        issue(2'b01, 0, 4'd1, 0, 0, 0, 0);
        chk_strobes("R4 instr miss", 5'b10011);
        chk("R7 third free way", alloc_way, 2);
        issue(2'b00, 0, 4'd1, 1, 4'd5, 1, 2'd3);
        chk_strobes("R5 hit beats dup", 5'b01000);
        issue(2'b01, 0, 4'd1, 1, 4'd5, 0, 0);
        chk_strobes("R5 instr hit", 5'b01000);
        issue(2'b00, 0, 4'd1, 0, 0, 1, 2'd2);
        chk_strobes("R6 snoop", 5'b00100);
        chk("R6 snoop core", snoop_core, 2);
        issue(2'b11, 0, 4'd1, 0, 0, 1, 2'd1);
        chk_strobes("R6 ntload snoop no alloc", 5'b00100);
        chk("R6 snoop core ntload", snoop_core, 1);
    endtask

    task automatic t_evict;
        for (int w = 0; w < 16; w++) begin
            issue(2'b10, 0, 4'd3, 0, 0, 0, 0);
            chk_strobes("R1 evict strobes", 5'b10000);
            chk("R7 fill order", alloc_way, w);
        end
        for (int w = 0; w < 3; w++) begin
            issue(2'b10, 0, 4'd3, 0, 0, 0, 0);
            chk("R8 round robin", alloc_way, w);
        end
        issue(2'b10, 0, 4'd3, 1, 4'd9, 0, 0);
        chk_strobes("R9 evict hit strobes", 5'b10000);
        chk("R9 hit way", alloc_way, 9);
        for (int w = 3; w < 16; w++) begin
            issue(2'b10, 0, 4'd3, 0, 0, 0, 0);
            chk("R9 R8 pointer after hit", alloc_way, w);
        end
        issue(2'b10, 0, 4'd3, 0, 0, 0, 0);
        chk("R8 wrap to 0", alloc_way, 0);
        issue(2'b10, 0, 4'd4, 0, 0, 0, 0);
        chk("R10 other set free", alloc_way, 0);
        issue(2'b10, 0, 4'd1, 0, 0, 0, 0);
        chk("R10 set1 next free", alloc_way, 3);
        @(negedge clk);
        chk_strobes("R11 idle after traffic", 5'b00000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reads();
        t_evict();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule